// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a direct-mapped data cache placed between a 32-bit processor load/store port and a slower, word-wide memory port. Every line holds a valid flag, a tag and a block of four 32-bit words. A read that hits returns its word in the same cycle. A read that misses stalls the processor. The cache then fetches the whole block from memory as four word reads, writes the tag, sets the valid flag and lets the held access retry, and the retry now hits.

Stores use write-through. A store updates the cached word and places the address and data in a small write buffer, which drains to memory in the background, so the processor does not wait for memory on each store. A store that misses first brings the block in, and the retried store then updates it. A read miss waits until the write buffer is empty before it fetches, so memory sees stores and fills in program order. The processor is also held while the buffer is full.

The index width is a parameter. The default of 6 index bits gives 64 lines; 12 index bits gives the 4K-line, 16-bit-tag organisation. Only word-aligned accesses are supported, and the two lowest address bits are not used.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses and stalls; with no request pending, `cpu_stall` and `mem_req` are low.
- R2: Address fields: word select is `cpu_addr[3:2]`, line index is `cpu_addr[IDX_W+3:4]` and tag is `cpu_addr[31:IDX_W+4]`; `cpu_addr[1:0]` has no effect on the result.
- R3: A read that hits completes in the cycle it is presented: `cpu_stall` is low and `cpu_rdata` carries the cached word.
- R4: A read miss holds `cpu_stall` high while the block is fetched as exactly four memory reads at the block-aligned address plus 0, 4, 8 and 12, in that order; the retried access then hits and returns the memory word.
- R5: Two addresses with the same index and different tags evict each other: after one is loaded, an access to the other misses.
- R6: A store that hits completes without a stall while the buffer has room, updates the cached word for later reads, and produces one memory write with the same address and data.
- R7: A store that misses first fetches the four words of its block, then writes its word; later reads return the stored word at that offset and the memory values at the other three.
- R8: While the write buffer holds `WB_DEPTH` entries, a store is stalled until an entry has been written to memory.
- R9: Memory writes leave in the order the stores were accepted, and no fill read is issued while a store is still waiting in the buffer.
- R10: A memory transfer completes on a cycle where `mem_req` and `mem_ready` are both high; while `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request is not stalled |
| cpu_stall | output | 1 | Access not completed this cycle; hold the request |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the requested transfer this cycle |

## Verification
The assertions take for granted that the processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` unchanged while `cpu_stall` is high. The retry-hit property depends on that. They also take for granted that memory returns read data in the same cycle as `mem_ready`. The bench drives each access from a task that keeps every processor input fixed until the stall drops. Its memory model answers after a programmable wait and presents read data in the cycle it raises ready.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int ADDR_W    = 32;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int WSEL_W    = $clog2(BLK_WORDS);
  localparam int BYTE_W    = 2;
  localparam int LINE_LSB  = WSEL_W + BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } dc_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wb_entry_t;
endpackage

// File: rtl/dc_rst_sync.sv
module dc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dc_store.sv
module dc_store
  import dc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      line_idx,
  input  logic [WSEL_W-1:0]     rd_word,
  output logic                  rd_valid,
  output logic [ADDR_W-IDX_W-LINE_LSB-1:0] rd_tag,
  output logic [WORD_W-1:0]     rd_data,
  input  logic                  fill_we,
  input  logic [WSEL_W-1:0]     fill_word,
  input  logic [WORD_W-1:0]     fill_data,
  input  logic                  tag_we,
  input  logic [ADDR_W-IDX_W-LINE_LSB-1:0] tag_wdata,
  input  logic                  cpu_we,
  input  logic [WSEL_W-1:0]     cpu_word,
  input  logic [WORD_W-1:0]     cpu_wdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - LINE_LSB;

  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] valid_d;
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [WORD_W-1:0] bank_rd [BLK_WORDS];

  always_comb begin
    valid_d = valid_q;
    if (tag_we) valid_d[line_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      valid_q <= '0;
    else if (tag_we) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_mem[line_idx] <= tag_wdata;
  end

  for (genvar b = 0; b < BLK_WORDS; b++) begin : g_bank
    logic [WORD_W-1:0] words [LINES];
    logic              bank_we;
    logic [WORD_W-1:0] bank_wd;

    assign bank_we = (fill_we && (fill_word == WSEL_W'(b))) ||
                     (cpu_we  && (cpu_word  == WSEL_W'(b)));
    assign bank_wd = fill_we ? fill_data : cpu_wdata;

    always_ff @(posedge clk) begin
      if (bank_we) words[line_idx] <= bank_wd;
    end

    assign bank_rd[b] = words[line_idx];
  end

  assign rd_valid = valid_q[line_idx];
  assign rd_tag   = tag_mem[line_idx];
  assign rd_data  = bank_rd[rd_word];

  // R7: a line fill and a processor store never write the data banks together
  a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_we && cpu_we));
endmodule

// File: rtl/dc_wbuf.sv
module dc_wbuf
  import dc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [WORD_W-1:0] head_data,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  wb_entry_t        slots [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d  = push ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + CNT_W'(1);
    if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (push || pop) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_q] <= '{addr: push_addr, data: push_data};
  end

  assign head_addr = slots[rd_q].addr;
  assign head_data = slots[rd_q].data;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));

  // R8: the controller never pushes into a full buffer
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9: the memory side never pops an empty buffer
  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
  import dc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              hit,
  output logic              cpu_stall,
  output logic              cache_we,
  output logic              fill_we,
  output logic [WSEL_W-1:0] fill_word,
  output logic              tag_we,
  output logic              wb_push,
  output logic              wb_pop,
  input  logic              wb_empty,
  input  logic              wb_full,
  input  logic [ADDR_W-1:0] wb_head_addr,
  input  logic [WORD_W-1:0] wb_head_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready
);
  dc_state_e         state_q, state_d;
  logic [WSEL_W-1:0] cnt_q, cnt_d;
  logic              in_idle, in_fill, accept, miss;

  assign in_idle = (state_q == ST_IDLE);
  assign in_fill = (state_q == ST_FILL);
  assign accept  = cpu_req && in_idle && hit && !(cpu_we && wb_full);
  assign miss    = cpu_req && in_idle && !hit;

  assign cpu_stall = cpu_req && !accept;
  assign cache_we  = accept && cpu_we;
  assign wb_push   = accept && cpu_we;

  assign mem_req   = in_fill || !wb_empty;
  assign mem_we    = !in_fill;
  assign mem_addr  = in_fill ? {cpu_addr[ADDR_W-1:LINE_LSB], cnt_q, {BYTE_W{1'b0}}}
                             : wb_head_addr;
  assign mem_wdata = wb_head_data;

  assign wb_pop    = !in_fill && !wb_empty && mem_ready;
  assign fill_we   = in_fill && mem_ready;
  assign fill_word = cnt_q;
  assign tag_we    = fill_we && (cnt_q == WSEL_W'(BLK_WORDS - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (miss) begin
          state_d = wb_empty ? ST_FILL : ST_DRAIN;
          cnt_d   = '0;
        end
      end
      ST_DRAIN: begin
        if (wb_empty) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (fill_we) begin
          cnt_d = cnt_q + WSEL_W'(1);
          if (tag_we) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R10: a waiting memory request keeps its command, address and data
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));
  // R9: a fill only runs once every buffered store has reached memory
  a_r9_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill |-> wb_empty);
  // R4: once the last fill word lands, a held retry hits
  a_r4_retry_hits: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> (!cpu_req || hit));
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dc_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  localparam int TAG_W   = ADDR_W - IDX_W - LINE_LSB;
  localparam int TAG_LSB = IDX_W + LINE_LSB;

  logic              rst_n_s;
  logic [IDX_W-1:0]  line_idx;
  logic [TAG_W-1:0]  addr_tag, rd_tag;
  logic [WSEL_W-1:0] word_sel, fill_word;
  logic              rd_valid, hit;
  logic              cache_we, fill_we, tag_we;
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [WORD_W-1:0] wb_head_data;

  assign line_idx = cpu_addr[TAG_LSB-1:LINE_LSB];
  assign addr_tag = cpu_addr[ADDR_W-1:TAG_LSB];
  assign word_sel = cpu_addr[LINE_LSB-1:BYTE_W];
  assign hit      = rd_valid && (rd_tag == addr_tag);

  dc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dc_store #(.IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .line_idx  (line_idx),
    .rd_word   (word_sel),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_data   (cpu_rdata),
    .fill_we   (fill_we),
    .fill_word (fill_word),
    .fill_data (mem_rdata),
    .tag_we    (tag_we),
    .tag_wdata (addr_tag),
    .cpu_we    (cache_we),
    .cpu_word  (word_sel),
    .cpu_wdata (cpu_wdata)
  );

  dc_wbuf #(.DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (wb_push),
    .push_addr ({cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}),
    .push_data (cpu_wdata),
    .pop       (wb_pop),
    .head_addr (wb_head_addr),
    .head_data (wb_head_data),
    .empty     (wb_empty),
    .full      (wb_full)
  );

  dc_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .hit          (hit),
    .cpu_stall    (cpu_stall),
    .cache_we     (cache_we),
    .fill_we      (fill_we),
    .fill_word    (fill_word),
    .tag_we       (tag_we),
    .wb_push      (wb_push),
    .wb_pop       (wb_pop),
    .wb_empty     (wb_empty),
    .wb_full      (wb_full),
    .wb_head_addr (wb_head_addr),
    .wb_head_data (wb_head_data),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ready    (mem_ready)
  );

  // R3: a load that completes was served from a valid, matching line
  a_r3_load_from_hit: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_req && !cpu_we && !cpu_stall) |-> (rd_valid && rd_tag == addr_tag));
  // R1: no request means no stall
  a_r1_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cpu_req |-> !cpu_stall);
endmodule

// File: tb/sim_dcache_wt.sv
module sim_dcache_wt;
  localparam int IDXW  = 6;
  localparam int DEPTH = 4;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dcache_wt #(.IDX_W(IDXW), .WB_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // ---------------- memory model ----------------
  logic [31:0] mview [logic [31:0]];
  logic [31:0] cview [logic [31:0]];
  int          lat = 2;
  int          wait_cnt = 0;
  logic        log_we   [1024];
  logic [31:0] log_addr [1024];
  logic [31:0] log_data [1024];
  int          log_n = 0;
  bit          pend = 0;
  logic [31:0] pend_addr, pend_data;
  logic        pend_we;
  int          hold_err = 0;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return mview.exists(a) ? mview[a] : init_val(a);
  endfunction

  function automatic logic [31:0] exp_val(input logic [31:0] a);
    logic [31:0] w = {a[31:2], 2'b00};
    return cview.exists(w) ? cview[w] : init_val(w);
  endfunction

  assign mem_ready = mem_req && (wait_cnt >= lat);
  assign mem_rdata = mem_val(mem_addr);

  always @(posedge clk) begin
    if (pend && mem_req &&
        (mem_addr != pend_addr || mem_we != pend_we ||
         (mem_we && mem_wdata != pend_data)))
      hold_err <= hold_err + 1;
    if (mem_req && mem_ready) begin
      if (log_n < 1024) begin
        log_we[log_n]   <= mem_we;
        log_addr[log_n] <= mem_addr;
        log_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
      end
      log_n <= log_n + 1;
      if (mem_we) mview[mem_addr] = mem_wdata;
      wait_cnt <= 0;
      pend     <= 0;
    end else if (mem_req) begin
      wait_cnt  <= wait_cnt + 1;
      pend      <= 1;
      pend_addr <= mem_addr;
      pend_we   <= mem_we;
      pend_data <= mem_wdata;
    end else begin
      pend <= 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    stalls = 0;
    forever begin
      #1;
      if (!cpu_stall || stalls > 5000) break;
      @(negedge clk);
      stalls++;
    end
    rd = cpu_rdata;
    if (we) cview[{a[31:2], 2'b00}] = wd;
    @(posedge clk);
    #1 cpu_req = 0; cpu_we = 0;
  endtask

  task automatic wait_mem_idle();
    int quiet = 0;
    for (int i = 0; i < 5000 && quiet < 3; i++) begin
      @(negedge clk);
      quiet = mem_req ? 0 : quiet + 1;
    end
  endtask

  localparam logic [31:0] A = 32'h0000_1230;
  localparam logic [31:0] B = 32'h0000_1630;
  localparam logic [31:0] C = 32'h0000_2040;
  localparam logic [31:0] D = 32'h0000_3358;

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(cpu_stall == 0, "R1", "stall idle after reset", 32'(cpu_stall), 0);
    chk(mem_req == 0, "R1", "mem_req idle after reset", 32'(mem_req), 0);
  endtask

  task automatic t_read_miss();
    logic [31:0] rd; int st; int base;
    lat  = 2;
    base = log_n;
    access(0, A, 0, rd, st);
    chk(st > 0, "R1", "first read stalls", 32'(st), 1);
    chk(rd == exp_val(A), "R4", "miss data", rd, exp_val(A));
    chk(log_n - base == 4, "R4", "fill read count", 32'(log_n - base), 4);
    for (int k = 0; k < 4; k++)
      chk(log_we[base+k] == 0 && log_addr[base+k] == ((A & ~32'hF) + 32'(4*k)),
          "R4", "fill address order", log_addr[base+k], (A & ~32'hF) + 32'(4*k));
  endtask

  task automatic t_read_hits();
    logic [31:0] rd; int st;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a = (A & ~32'hF) + 32'(4*k);
      access(0, a, 0, rd, st);
      chk(st == 0, "R3", "hit without stall", 32'(st), 0);
      chk(rd == exp_val(a), "R3", "hit data", rd, exp_val(a));
    end
    access(0, A | 32'h3, 0, rd, st);
    chk(st == 0 && rd == exp_val(A), "R2", "byte bits ignored", rd, exp_val(A));
  endtask

  task automatic t_conflict();
    logic [31:0] rd; int st;
    access(0, B, 0, rd, st);
    chk(st > 0, "R5", "conflicting tag misses", 32'(st), 1);
    chk(rd == exp_val(B), "R5", "conflict data", rd, exp_val(B));
    access(0, A, 0, rd, st);
    chk(st > 0, "R5", "evicted line misses again", 32'(st), 1);
    chk(rd == exp_val(A), "R2", "tag field separates lines", rd, exp_val(A));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int st; int base;
    base = log_n;
    access(1, A + 4, 32'hCAFE_0001, rd, st);
    chk(st == 0, "R6", "store hit no stall", 32'(st), 0);
    wait_mem_idle();
    chk(log_n - base == 1, "R6", "one memory write", 32'(log_n - base), 1);
    chk(log_we[base] == 1 && log_addr[base] == A + 4, "R6", "write address",
        log_addr[base], A + 4);
    chk(log_data[base] == 32'hCAFE_0001, "R6", "write data", log_data[base], 32'hCAFE_0001);
    access(0, A + 4, 0, rd, st);
    chk(st == 0 && rd == 32'hCAFE_0001, "R6", "read after store", rd, 32'hCAFE_0001);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int st; int base;
    base = log_n;
    access(1, D, 32'hBEEF_0002, rd, st);
    chk(st > 0, "R7", "store miss stalls", 32'(st), 1);
    wait_mem_idle();
    chk(log_n - base == 5, "R7", "fill then write", 32'(log_n - base), 5);
    chk(log_we[base] == 0 && log_we[base+4] == 1, "R7", "reads before write",
        32'(log_we[base+4]), 1);
    access(0, D, 0, rd, st);
    chk(st == 0 && rd == 32'hBEEF_0002, "R7", "stored word", rd, 32'hBEEF_0002);
    access(0, D & ~32'hF, 0, rd, st);
    chk(st == 0 && rd == exp_val(D & ~32'hF), "R7", "neighbour word", rd,
        exp_val(D & ~32'hF));
  endtask

  task automatic t_buffer_full();
    logic [31:0] rd; int st; int base; int st_sum;
    lat = 20; base = log_n; st_sum = 0;
    for (int k = 0; k < DEPTH; k++) begin
      access(1, (A & ~32'hF) + 32'(4*(k%4)), 32'h1000_0000 + 32'(k), rd, st);
      st_sum += st;
    end
    chk(st_sum == 0, "R8", "stores until full", 32'(st_sum), 0);
    access(1, A + 8, 32'h1000_00FF, rd, st);
    chk(st > 0, "R8", "store on full buffer stalls", 32'(st), 1);
    wait_mem_idle();
    chk(log_n - base == DEPTH + 1, "R9", "write count", 32'(log_n - base), DEPTH + 1);
    for (int k = 0; k < DEPTH; k++)
      chk(log_data[base+k] == 32'h1000_0000 + 32'(k), "R9", "write order",
          log_data[base+k], 32'h1000_0000 + 32'(k));
    lat = 2;
  endtask

  task automatic t_drain_before_fill();
    logic [31:0] rd; int st; int base;
    lat = 8; base = log_n;
    access(1, A, 32'h7777_0003, rd, st);
    access(1, A + 12, 32'h7777_0004, rd, st);
    access(0, C, 0, rd, st);
    wait_mem_idle();
    chk(log_n - base == 6, "R9", "transfer count", 32'(log_n - base), 6);
    chk(log_we[base] == 1 && log_we[base+1] == 1 && log_we[base+2] == 0,
        "R9", "writes precede fill", 32'(log_we[base+2]), 0);
    chk(rd == exp_val(C), "R4", "read after drain", rd, exp_val(C));
    chk(hold_err == 0, "R10", "request held while waiting", 32'(hold_err), 0);
    lat = 2;
  endtask

  initial begin
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    t_reset();
    t_read_miss();
    t_read_hits();
    t_conflict();
    t_write_hit();
    t_write_miss();
    t_buffer_full();
    t_drain_before_fill();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule